// File: doc/BRIEF.md
# UART Line Status Register

This block holds the eight-bit line status byte of a serial port that can run either as a single-buffer receiver/transmitter (one holding register per direction) or as a FIFO-buffered one. The receive path reports each incoming character with a strobe and three error tags: bad parity, missing stop bit and a line held silent for a whole character. The transmit path reports when the holding register hands a character to the shifter, whether the transmit FIFO is empty and whether the shifter is idle. The CPU side provides a data-read strobe, a data-write strobe and a status-read strobe.

The data bytes and their FIFOs live outside the block. Inside, a small tag queue mirrors the receive FIFO's occupancy and holds the three error tags of each stored character. This lets the block report the tags of the character at the head, detect a full receive buffer, and count the errored characters that remain. Sticky bits are cleared by a status read. The read returns the value from before the clear. A transmit-empty interrupt request is raised while the holding-empty bit is set and the interrupt is enabled.

Top module: `uart_line_status`

## Requirements
- R1: After reset, status_byte reads 0x60: bit 5 (holding empty) and bit 6 (transmitter empty) are 1 and every other bit is 0.
- R2: Bit 0 (data ready) is 1 exactly while at least one received character is stored and unread. It reads 0 in the cycle after the last stored character is read out.
- R3: In single-buffer mode (fifo_mode=0), a character strobe that arrives while the holding register is occupied, with no data read in the same cycle, sets bit 1 (overrun). The new character replaces the old one, so bit 0 stays 1 and a single data read empties the buffer.
- R4: In FIFO mode (fifo_mode=1), a character strobe that arrives while DEPTH characters are stored, with no data read in the same cycle, sets bit 1. The character is discarded, its tags affect neither bits 2 to 4 nor bit 7, and exactly DEPTH data reads then empty the buffer.
- R5: Bits 1 to 4 are sticky and clear in the cycle after a status read. The byte presented during the read cycle is the value before the clear.
- R6: If an event that sets bit 1 to 4 coincides with a status read, the bit is 1 after that cycle.
- R7: In FIFO mode, bits 2 (parity), 3 (stop bit missing) and 4 (silent line) show the tags of the character at the head of the receive FIFO. They load whenever the head changes and read 0 once the FIFO is empty. In single-buffer mode they accumulate the tags of every accepted character.
- R8: Bit 7 reads 0 in single-buffer mode. In FIFO mode it becomes 1 once a stored character carries any error tag. A status read clears it only if no errored character remains stored.
- R9: Bit 5 clears on tx_data_write. In single-buffer mode it sets on tx_hold_to_shift. In FIFO mode it sets on a rising edge of tx_fifo_empty, and tx_hold_to_shift has no effect on it.
- R10: Bit 6 is registered one cycle after its inputs. In single-buffer mode it equals bit 5 AND tx_shift_idle. In FIFO mode it equals tx_fifo_empty AND tx_shift_idle. A write forces it to 0.
- R11: tx_irq is 1 exactly while bit 5 is 1 and tx_irq_en is 1.
- R12: A change of fifo_mode empties the receive tag queue and clears bits 0 to 4 and bit 7 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 0 selects single-buffer behaviour, 1 selects FIFO behaviour |
| rx_char_strobe | input | 1 | A received character is offered to the receive buffer |
| rx_parity_bad | input | 1 | Tag with the strobe: parity check failed |
| rx_stop_missing | input | 1 | Tag with the strobe: no stop bit |
| rx_line_silent | input | 1 | Tag with the strobe: line silent for a whole character |
| rx_data_read | input | 1 | CPU reads one received character |
| tx_data_write | input | 1 | CPU writes one transmit character |
| tx_hold_to_shift | input | 1 | Single-buffer mode: holding register moved into the shifter |
| tx_fifo_empty | input | 1 | FIFO mode: transmit FIFO holds nothing |
| tx_shift_idle | input | 1 | Transmit shifter holds nothing |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| stat_rd | input | 1 | CPU reads the status byte |
| status_byte | output | 8 | Current status byte |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest state to reach from the ports is a FIFO holding several characters with different error tags. In that state the head's flags, the errored-character summary and the clear-on-read rule all act at once. The stimulus pushes a clean character, a framing-error character and a silent-line character, then alternates status reads with data reads. Each read therefore lands with errored characters still queued behind the head, and the summary bit must survive every read until the last errored entry is gone. The full-FIFO overrun is reached by pushing DEPTH characters without reads and then one tagged extra. Counting the reads needed to drain the buffer shows that the extra character was dropped.

// File: rtl/uart_ls_pkg.sv
package uart_ls_pkg;

  typedef struct packed {
    logic silent;
    logic nostop;
    logic parity;
  } rx_tag_t;

  localparam int unsigned ST_READY   = 0;
  localparam int unsigned ST_OVERRUN = 1;
  localparam int unsigned ST_PARITY  = 2;
  localparam int unsigned ST_NOSTOP  = 3;
  localparam int unsigned ST_SILENT  = 4;
  localparam int unsigned ST_THR_MT  = 5;
  localparam int unsigned ST_TX_MT   = 6;
  localparam int unsigned ST_RXF_ERR = 7;

endpackage

// File: rtl/ls_rx_tag_queue.sv
module ls_rx_tag_queue
  import uart_ls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fifo_mode,
  input  logic             push,
  input  rx_tag_t          push_tag,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_any_d,
  output logic             accept,
  output logic             overrun_evt,
  output logic             head_chg,
  output rx_tag_t          head_tag_d
);

  rx_tag_t          mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_ptr_d, wr_ptr_d, rd_ptr_inc;
  logic [CNT_W-1:0] count_d, err_cnt_d;
  logic             cap_full, pop_ok, push_ok, overwrite;
  rx_tag_t          head_tag;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign head_tag   = mem[rd_ptr];
  assign rd_ptr_inc = ptr_inc(rd_ptr);
  assign cap_full   = fifo_mode ? (count == CNT_W'(DEPTH)) : (count != '0);
  assign pop_ok     = pop && (count != '0);
  assign push_ok    = push && (!cap_full || pop_ok);
  assign overwrite  = push && cap_full && !pop_ok && !fifo_mode;
  assign overrun_evt = push && cap_full && !pop_ok;
  assign accept     = push_ok || overwrite;

  always_comb begin
    count_d   = count;
    err_cnt_d = err_cnt;
    rd_ptr_d  = rd_ptr;
    wr_ptr_d  = wr_ptr;
    if (push_ok) begin
      wr_ptr_d = ptr_inc(wr_ptr);
      count_d  = count_d + CNT_W'(1);
      if (|push_tag) err_cnt_d = err_cnt_d + CNT_W'(1);
    end
    if (pop_ok) begin
      rd_ptr_d = rd_ptr_inc;
      count_d  = count_d - CNT_W'(1);
      if (|head_tag) err_cnt_d = err_cnt_d - CNT_W'(1);
    end
    if (overwrite) begin
      if (|head_tag) err_cnt_d = err_cnt_d - CNT_W'(1);
      if (|push_tag) err_cnt_d = err_cnt_d + CNT_W'(1);
    end
    if (flush) begin
      count_d   = '0;
      err_cnt_d = '0;
      rd_ptr_d  = '0;
      wr_ptr_d  = '0;
    end
  end

  always_comb begin
    head_chg   = 1'b0;
    head_tag_d = '0;
    if (overwrite) begin
      head_chg   = 1'b1;
      head_tag_d = push_tag;
    end else if (pop_ok) begin
      head_chg = 1'b1;
      if (count > CNT_W'(1))  head_tag_d = mem[rd_ptr_inc];
      else if (push_ok)       head_tag_d = push_tag;
    end else if (push_ok && (count == '0)) begin
      head_chg   = 1'b1;
      head_tag_d = push_tag;
    end
  end

  assign err_any_d = (err_cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      err_cnt <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
    end else begin
      count   <= count_d;
      err_cnt <= err_cnt_d;
      rd_ptr  <= rd_ptr_d;
      wr_ptr  <= wr_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush)   mem[wr_ptr] <= push_tag;
    if (overwrite && !flush) mem[rd_ptr] <= push_tag;
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !flush && push && !pop && count == CNT_W'(DEPTH))
      |=> (count == CNT_W'(DEPTH)));

  p_single_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !flush && count <= CNT_W'(1)) |=> (count <= CNT_W'(1)));

endmodule

// File: rtl/ls_rx_flags.sv
module ls_rx_flags
  import uart_ls_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    fifo_mode,
  input  logic    stat_rd,
  input  logic    accept,
  input  rx_tag_t push_tag,
  input  logic    overrun_evt,
  input  logic    head_chg,
  input  rx_tag_t head_tag_d,
  input  logic    err_any_d,
  output logic    ovr_q,
  output rx_tag_t err_q,
  output logic    rxfe_q
);

  logic    ovr_d, rxfe_d;
  rx_tag_t err_d, err_kept;

  assign err_kept = stat_rd ? rx_tag_t'('0) : err_q;

  always_comb begin
    if (flush) begin
      ovr_d  = 1'b0;
      err_d  = '0;
      rxfe_d = 1'b0;
    end else begin
      ovr_d  = overrun_evt || (ovr_q && !stat_rd);
      rxfe_d = err_any_d || (rxfe_q && !stat_rd);
      if (fifo_mode) begin
        err_d = head_chg ? head_tag_d : err_kept;
      end else begin
        err_d = err_kept | (accept ? push_tag : rx_tag_t'('0));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      err_q  <= '0;
      rxfe_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_d;
      err_q  <= err_d;
      rxfe_q <= rxfe_d;
    end
  end

  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !stat_rd && !flush) |=> ovr_q);

  p_event_beats_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !flush) |=> ovr_q);

  p_read_clears_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !overrun_evt) |=> !ovr_q);

endmodule

// File: rtl/ls_tx_flags.sv
module ls_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic tx_data_write,
  input  logic tx_hold_to_shift,
  input  logic tx_fifo_empty,
  input  logic tx_shift_idle,
  input  logic tx_irq_en,
  output logic thre_q,
  output logic temt_q,
  output logic tx_irq
);

  logic fe_q, thre_d, temt_d, set_thre;

  assign set_thre = fifo_mode ? (tx_fifo_empty && !fe_q) : tx_hold_to_shift;

  always_comb begin
    if (tx_data_write)  thre_d = 1'b0;
    else if (set_thre)  thre_d = 1'b1;
    else                thre_d = thre_q;
    temt_d = (fifo_mode ? tx_fifo_empty : thre_d) && tx_shift_idle && !tx_data_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q <= 1'b1;
      temt_q <= 1'b1;
      fe_q   <= 1'b1;
    end else begin
      thre_q <= thre_d;
      temt_q <= temt_d;
      fe_q   <= tx_fifo_empty;
    end
  end

  assign tx_irq = thre_q && tx_irq_en;

  p_write_clears_thre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_write |=> !thre_q);

  p_temt_needs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_shift_idle |=> !temt_q);

  p_single_temt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !thre_d) |=> !temt_q);

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_ls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       rx_char_strobe,
  input  logic       rx_parity_bad,
  input  logic       rx_stop_missing,
  input  logic       rx_line_silent,
  input  logic       rx_data_read,
  input  logic       tx_data_write,
  input  logic       tx_hold_to_shift,
  input  logic       tx_fifo_empty,
  input  logic       tx_shift_idle,
  input  logic       tx_irq_en,
  input  logic       stat_rd,
  output logic [7:0] status_byte,
  output logic       tx_irq
);

  logic             mode_q, flush;
  rx_tag_t          in_tag, head_tag_d, err_q;
  logic [CNT_W-1:0] count, err_cnt;
  logic             err_any_d, accept, overrun_evt, head_chg;
  logic             ovr_q, rxfe_q, thre_q, temt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign flush  = (fifo_mode != mode_q);
  assign in_tag = '{silent: rx_line_silent, nostop: rx_stop_missing, parity: rx_parity_bad};

  ls_rx_tag_queue #(.DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fifo_mode  (fifo_mode),
    .push       (rx_char_strobe),
    .push_tag   (in_tag),
    .pop        (rx_data_read),
    .count      (count),
    .err_cnt    (err_cnt),
    .err_any_d  (err_any_d),
    .accept     (accept),
    .overrun_evt(overrun_evt),
    .head_chg   (head_chg),
    .head_tag_d (head_tag_d)
  );

  ls_rx_flags u_rx_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fifo_mode  (fifo_mode),
    .stat_rd    (stat_rd),
    .accept     (accept),
    .push_tag   (in_tag),
    .overrun_evt(overrun_evt),
    .head_chg   (head_chg),
    .head_tag_d (head_tag_d),
    .err_any_d  (err_any_d),
    .ovr_q      (ovr_q),
    .err_q      (err_q),
    .rxfe_q     (rxfe_q)
  );

  ls_tx_flags u_tx_flags (
    .clk             (clk),
    .rst_n           (rst_n),
    .fifo_mode       (fifo_mode),
    .tx_data_write   (tx_data_write),
    .tx_hold_to_shift(tx_hold_to_shift),
    .tx_fifo_empty   (tx_fifo_empty),
    .tx_shift_idle   (tx_shift_idle),
    .tx_irq_en       (tx_irq_en),
    .thre_q          (thre_q),
    .temt_q          (temt_q),
    .tx_irq          (tx_irq)
  );

  always_comb begin
    status_byte             = '0;
    status_byte[ST_READY]   = (count != '0);
    status_byte[ST_OVERRUN] = ovr_q;
    status_byte[ST_PARITY]  = err_q.parity;
    status_byte[ST_NOSTOP]  = err_q.nostop;
    status_byte[ST_SILENT]  = err_q.silent;
    status_byte[ST_THR_MT]  = thre_q;
    status_byte[ST_TX_MT]   = temt_q;
    status_byte[ST_RXF_ERR] = rxfe_q && fifo_mode;
  end

  p_summary_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> rxfe_q);

  p_flush_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !ovr_q && err_q == '0));

  p_errcnt_le_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= count);

endmodule

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb_top;

  localparam int unsigned DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b0;
  logic       rx_char_strobe = 1'b0, rx_parity_bad = 1'b0, rx_stop_missing = 1'b0, rx_line_silent = 1'b0;
  logic       rx_data_read = 1'b0, tx_data_write = 1'b0, tx_hold_to_shift = 1'b0;
  logic       tx_fifo_empty = 1'b1, tx_shift_idle = 1'b1, tx_irq_en = 1'b0, stat_rd = 1'b0;
  logic [7:0] status_byte;
  logic       tx_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_line_status #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_char_strobe(rx_char_strobe), .rx_parity_bad(rx_parity_bad),
    .rx_stop_missing(rx_stop_missing), .rx_line_silent(rx_line_silent),
    .rx_data_read(rx_data_read), .tx_data_write(tx_data_write),
    .tx_hold_to_shift(tx_hold_to_shift), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_idle(tx_shift_idle), .tx_irq_en(tx_irq_en), .stat_rd(stat_rd),
    .status_byte(status_byte), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic push(input logic [2:0] tag);
    {rx_line_silent, rx_stop_missing, rx_parity_bad} = tag;
    rx_char_strobe = 1'b1;
    tick();
    rx_char_strobe = 1'b0;
    {rx_line_silent, rx_stop_missing, rx_parity_bad} = 3'b000;
  endtask

  task automatic pop();
    rx_data_read = 1'b1;
    tick();
    rx_data_read = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    stat_rd = 1'b1;
    #0.5 v = status_byte;
    tick();
    stat_rd = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    fifo_mode = m;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 reset value", status_byte, 8'h60);
    chk("R11 irq low when disabled", {7'd0, tx_irq}, 8'h00);
  endtask

  task automatic t_single_basic();
    push(3'b000);
    chk("R2 ready after char", status_byte, 8'h61);
    pop();
    chk("R2 ready drops after read", status_byte, 8'h60);
  endtask

  task automatic t_single_overrun();
    logic [7:0] v;
    push(3'b001);
    chk("R8 single mode bit7 stays 0 with error", status_byte, 8'h65);
    push(3'b000);
    chk("R3 overrun on occupied holding", status_byte, 8'h67);
    rd_status(v);
    chk("R5 read returns pre-clear value", v, 8'h67);
    chk("R5 sticky bits cleared after read", status_byte, 8'h61);
    pop();
    chk("R3 one read empties after overwrite", status_byte, 8'h60);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    rx_parity_bad = 1'b1;
    rx_char_strobe = 1'b1;
    stat_rd = 1'b1;
    #0.5 v = status_byte;
    tick();
    stat_rd = 1'b0; rx_char_strobe = 1'b0; rx_parity_bad = 1'b0;
    chk("R6 read data before event", v, 8'h60);
    chk("R6 event wins over read", status_byte, 8'h65);
    rd_status(v);
    chk("R5 parity cleared", status_byte, 8'h61);
    pop();
  endtask

  task automatic t_fifo_head();
    logic [7:0] v;
    set_mode(1'b1);
    chk("R12 empty after entering fifo mode", status_byte, 8'h60);
    push(3'b000);
    chk("R2 ready in fifo mode", status_byte, 8'h61);
    push(3'b010);
    push(3'b100);
    chk("R7 clean head hides queued errors", status_byte, 8'hE1);
    rd_status(v);
    chk("R8 summary kept while errors stored", status_byte, 8'hE1);
    pop();
    chk("R7 head stop-missing shown", status_byte, 8'hE9);
    rd_status(v);
    chk("R5 head flag cleared by read", status_byte, 8'hE1);
    pop();
    chk("R7 head silent shown", status_byte, 8'hF1);
    pop();
    chk("R7 flags zero when empty, R8 summary held", status_byte, 8'hE0);
    rd_status(v);
    chk("R8 summary cleared when none remain", status_byte, 8'h60);
  endtask

  task automatic t_fifo_full();
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) push(3'b000);
    chk("R4 full fifo ready", status_byte, 8'h61);
    push(3'b001);
    chk("R4 overrun, dropped tag unseen", status_byte, 8'h63);
    rd_status(v);
    chk("R5 overrun cleared", status_byte, 8'h61);
    for (int i = 0; i < DEPTH - 1; i++) pop();
    chk("R4 one character left", status_byte, 8'h61);
    pop();
    chk("R4 empty after DEPTH reads", status_byte, 8'h60);
  endtask

  task automatic t_mode_flush();
    push(3'b001);
    chk("R7 parity head with summary", status_byte, 8'hE5);
    set_mode(1'b0);
    chk("R12 mode change clears receive state", status_byte, 8'h60);
  endtask

  task automatic t_tx_single();
    tx_irq_en = 1'b1;
    tx_data_write = 1'b1; tx_shift_idle = 1'b0;
    tick();
    tx_data_write = 1'b0;
    chk("R9 write clears holding empty", status_byte, 8'h00);
    chk("R11 irq low while not empty", {7'd0, tx_irq}, 8'h00);
    tx_hold_to_shift = 1'b1;
    tick();
    tx_hold_to_shift = 1'b0;
    chk("R10 shifter busy keeps bit6 low", status_byte, 8'h20);
    chk("R11 irq high when empty and enabled", {7'd0, tx_irq}, 8'h01);
    tx_shift_idle = 1'b1;
    tick();
    chk("R10 transmitter empty", status_byte, 8'h60);
    tx_irq_en = 1'b0;
    #0.5 chk("R11 irq low when disabled", {7'd0, tx_irq}, 8'h00);
  endtask

  task automatic t_tx_fifo();
    set_mode(1'b1);
    tx_data_write = 1'b1; tx_fifo_empty = 1'b0; tx_shift_idle = 1'b0;
    tick();
    tx_data_write = 1'b0;
    chk("R9 fifo write clears", status_byte, 8'h00);
    tx_hold_to_shift = 1'b1;
    tick();
    tx_hold_to_shift = 1'b0;
    chk("R9 hold-to-shift ignored in fifo mode", status_byte, 8'h00);
    tx_fifo_empty = 1'b1;
    tick();
    chk("R9 fifo empty edge sets bit5", status_byte, 8'h20);
    tx_shift_idle = 1'b1;
    tick();
    chk("R10 fifo and shifter empty", status_byte, 8'h60);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single_basic();
    t_single_overrun();
    t_same_cycle();
    t_fifo_head();
    t_fifo_full();
    t_mode_flush();
    t_tx_single();
    t_tx_fifo();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule